// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register

This block is the digital front end of a 14-bit voltage-output converter that is loaded over a three-wire serial link. A host frames each transfer with an active-low select, clocks data in most-significant bit first, and the sampled bits enter a shift register that always holds the latest fourteen bits it has seen. A separate holding register drives the code that the converter core uses. That code changes only when the holding register takes a copy of the shift register.

The copy happens in one of two ways, chosen by a mode input. In automatic mode the copy happens as select rises, provided the frame clocked at least one bit. In strobed mode the copy is made on the falling edge of an active-low load strobe. If the strobe falls while a frame is still open, the copy waits until select rises. The shift register is not cleared by reset. A frame shorter than fourteen bits therefore merges with what is already there, while the holding register starts at zero. A host that sends 16-bit words needs no change: the two leading bits are pushed out.

All serial pins are oversampled by the system clock through synchronizer chains. The system clock must run at least four times faster than the serial clock. Each copy into the holding register is marked by a one-cycle update pulse.

Top module: `serdac_front`

## Requirements
- R1: While reset is asserted and after it is released, the code output is all zeros and the update pulse is low until the first copy.
- R2: A data bit is sampled on each rising edge of the serial clock while select is low, most-significant bit first. In automatic mode, a 14-bit frame appears on the code output when select rises.
- R3: A frame with more than 14 serial clock edges keeps only the last 14 bits, so a 16-bit word loads its lower 14 bits.
- R4: A frame of n < 14 bits yields the previous shift contents moved up by n positions, with the new bits in the n low positions.
- R5: In automatic mode, a select pulse with no serial clock edge makes no copy and no update pulse.
- R6: In strobed mode, a rising select alone does not change the code. A falling load strobe while select is high copies the shift register.
- R7: In strobed mode, a load strobe that falls while select is low leaves the code unchanged until select rises, and the copy is then made.
- R8: The update pulse is high for exactly one system clock for each copy, and the code output never changes without it.
- R9: The code changes on the third rising system clock edge after the pin edge that triggers the copy: two synchronizer stages plus the edge register.
- R10: Serial clock edges that occur while select is high do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| csn_i | input | 1 | Active-low frame select |
| ldn_i | input | 1 | Active-low load strobe (strobed mode) |
| auto_upd_i | input | 1 | 1 = copy at end of frame, 0 = copy on load strobe |
| code_o | output | 14 | Holding register, converter code |
| upd_o | output | 1 | One-cycle pulse on each copy |

## Verification
A wrong shift register content stays hidden until the next copy. It then shows up three system clocks after the triggering pin edge, as a code value that differs from the word the bench computed. A short frame makes the error worse, because stale upper bits are carried forward. A lost or stuck pending-strobe flag shows up as a code change that arrives too early, while select is still low, or not at all at the closing select edge. A wrong frame-activity flag shows up at the close of an empty frame as a spurious update pulse. Both the code and the pulse are compared with a behavioural model on every clock, so any of these faults is reported in the cycle it appears.

// File: rtl/serdac_pkg.sv
`timescale 1ns/1ps
package serdac_pkg;
   localparam int CODE_W      = 14;
   localparam int SYNC_STAGES = 2;

   // serial pins carried through one synchronizer bank
   typedef struct packed {
      logic ldn;
      logic csn;
      logic sdi;
      logic sclk;
   } pins_t;

   localparam int   PINS_W    = $bits(pins_t);
   localparam pins_t PINS_IDLE = '{ldn: 1'b1, csn: 1'b1, sdi: 1'b0, sclk: 1'b0};

   typedef enum logic {
      UPD_STROBE = 1'b0,
      UPD_AUTO   = 1'b1
   } upd_mode_e;
endpackage

// File: rtl/serdac_sync_edge.sv
`timescale 1ns/1ps
module serdac_sync_edge #(
   parameter int               W      = 1,
   parameter int               STAGES = 2,
   parameter logic [W-1:0]     IDLE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("serdac_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];
   logic [W-1:0] prev_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= IDLE;
               else        chain[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= IDLE;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= chain[LAST];
   end

   assign lvl  = chain[LAST];
   assign rise = chain[LAST] & ~prev_q;
   assign fall = ~chain[LAST] & prev_q;
endmodule

// File: rtl/serdac_shifter.sv
`timescale 1ns/1ps
module serdac_shifter #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] word
);
   generate
      if (W < 2) begin : g_bad_width
         $error("serdac_shifter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] sh_q;

   // deliberately not reset: contents persist across frames and reset
   always_ff @(posedge clk) begin
      if (shift_en) sh_q <= {sh_q[W-2:0], din};
   end

   assign word = sh_q;

   // R10: without a qualified serial edge the register holds
   a_r10_idle_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/serdac_update_ctrl.sv
`timescale 1ns/1ps
module serdac_update_ctrl #(
   parameter int W          = 14,
   parameter bit HAS_STROBE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         auto_mode,
   input  logic         cs_lvl,
   input  logic         cs_rise,
   input  logic         cs_fall,
   input  logic         shift_en,
   input  logic         ld_fall,
   input  logic [W-1:0] word,
   output logic [W-1:0] code,
   output logic         upd
);
   import serdac_pkg::*;

   upd_mode_e mode;
   logic      got_q;
   logic      pend_q;
   logic      auto_load;
   logic      strobe_load;
   logic      load;
   logic [W-1:0] code_q;
   logic         upd_q;

   assign mode = (HAS_STROBE && !auto_mode) ? UPD_STROBE : UPD_AUTO;

   // a frame counts only if it clocked at least one bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                got_q <= 1'b0;
      else if (shift_en)         got_q <= 1'b1;
      else if (cs_fall | cs_rise) got_q <= 1'b0;
   end

   assign auto_load = (mode == UPD_AUTO) && cs_rise && got_q;

   generate
      if (HAS_STROBE) begin : g_strobe
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    pend_q <= 1'b0;
            else if (mode == UPD_AUTO)     pend_q <= 1'b0;
            else if (ld_fall && !cs_lvl)   pend_q <= 1'b1;
            else if (cs_rise)              pend_q <= 1'b0;
         end
         assign strobe_load = (mode == UPD_STROBE) &&
                              ((ld_fall && cs_lvl) || (cs_rise && pend_q));
      end else begin : g_no_strobe
         assign pend_q      = 1'b0;
         assign strobe_load = 1'b0;
      end
   endgenerate

   assign load = auto_load | strobe_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= load;
         if (load) code_q <= word;
      end
   end

   assign code = code_q;
   assign upd  = upd_q;

   // R8: the code never moves without the update pulse
   a_r8_code_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q != $past(code_q)) |-> upd_q);

   // R5: an empty frame in automatic mode makes no copy
   a_r5_empty_frame_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == UPD_AUTO && cs_rise && !got_q) |=> !upd_q);

   // R6: in strobed mode a closing select alone makes no copy
   a_r6_cs_alone_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == UPD_STROBE && cs_rise && !pend_q && !ld_fall) |=> !upd_q);

   // R7: a deferred strobe is only ever recorded inside an open frame
   a_r7_pend_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(!cs_lvl));
endmodule

// File: rtl/serdac_front.sv
`timescale 1ns/1ps
module serdac_front #(
   parameter int CODE_W      = serdac_pkg::CODE_W,
   parameter int SYNC_STAGES = serdac_pkg::SYNC_STAGES,
   parameter bit HAS_STROBE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdi_i,
   input  logic              csn_i,
   input  logic              ldn_i,
   input  logic              auto_upd_i,
   output logic [CODE_W-1:0] code_o,
   output logic              upd_o
);
   import serdac_pkg::*;

   pins_t pins_raw;
   pins_t pins_lvl;
   pins_t pins_rise;
   pins_t pins_fall;
   logic  shift_en;
   logic [CODE_W-1:0] word;

   assign pins_raw = '{ldn: ldn_i, csn: csn_i, sdi: sdi_i, sclk: sclk_i};

   serdac_sync_edge #(
      .W      (PINS_W),
      .STAGES (SYNC_STAGES),
      .IDLE   (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .lvl   (pins_lvl),
      .rise  (pins_rise),
      .fall  (pins_fall)
   );

   // data bit is taken from the same synchronizer stage as the clock edge
   assign shift_en = pins_rise.sclk & ~pins_lvl.csn;

   serdac_shifter #(
      .W (CODE_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (pins_lvl.sdi),
      .word     (word)
   );

   serdac_update_ctrl #(
      .W          (CODE_W),
      .HAS_STROBE (HAS_STROBE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .auto_mode (auto_upd_i),
      .cs_lvl    (pins_lvl.csn),
      .cs_rise   (pins_rise.csn),
      .cs_fall   (pins_fall.csn),
      .shift_en  (shift_en),
      .ld_fall   (pins_fall.ldn),
      .word      (word),
      .code      (code_o),
      .upd       (upd_o)
   );

   // unused edge directions of the data and strobe pins
   logic unused_edges;
   assign unused_edges = ^{pins_rise.sdi, pins_fall.sdi, pins_rise.ldn,
                           pins_fall.sclk, pins_lvl.ldn, pins_lvl.sclk};
endmodule

// File: tb/serdac_front_test.sv
`timescale 1ns/1ps
module serdac_front_test;
   localparam int W    = 14;
   localparam int MASK = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, sdi = 1'b0, csn = 1'b1, ldn = 1'b1, auto_upd = 1'b1;
   logic [W-1:0] code;
   logic         upd;

   int checks = 0;
   int errors = 0;
   int pulses = 0;

   always #4 clk = ~clk;

   serdac_front uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_i     (sclk),
      .sdi_i      (sdi),
      .csn_i      (csn),
      .ldn_i      (ldn),
      .auto_upd_i (auto_upd),
      .code_o     (code),
      .upd_o      (upd)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // pin history: h[0] newest sample; the design acts on h[1] vs h[2]
   int hs[$], hd[$], hc[$], hl[$];
   int ref_sh = 0, ref_code = 0, ref_upd = 0, ref_got = 0, ref_pend = 0;

   function automatic void hist_reset();
      hs = '{0, 0, 0}; hd = '{0, 0, 0}; hc = '{1, 1, 1}; hl = '{1, 1, 1};
   endfunction

   initial hist_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         hist_reset();
         ref_code = 0; ref_upd = 0; ref_got = 0; ref_pend = 0;
      end else begin
         bit s_rise, c_rise, c_fall, l_fall, cs_low, en, load;
         s_rise = (hs[1] == 1) && (hs[2] == 0);
         c_rise = (hc[1] == 1) && (hc[2] == 0);
         c_fall = (hc[1] == 0) && (hc[2] == 1);
         l_fall = (hl[1] == 0) && (hl[2] == 1);
         cs_low = (hc[1] == 0);
         en     = s_rise && cs_low;
         load   = 1'b0;
         if (auto_upd) begin
            load = c_rise && (ref_got != 0);
            ref_pend = 0;
         end else begin
            load = (l_fall && !cs_low) || (c_rise && ref_pend != 0);
            if (l_fall && cs_low) ref_pend = 1;
            else if (c_rise)      ref_pend = 0;
         end
         if (load) ref_code = ref_sh;
         ref_upd = load;
         if (en)                    ref_got = 1;
         else if (c_fall || c_rise) ref_got = 0;
         if (en) ref_sh = ((ref_sh << 1) | hd[1]) & MASK;
         void'(hs.pop_back()); void'(hd.pop_back());
         void'(hc.pop_back()); void'(hl.pop_back());
         hs.push_front(int'(sclk)); hd.push_front(int'(sdi));
         hc.push_front(int'(csn));  hl.push_front(int'(ldn));
      end
   end

   // compared on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R9 code per cycle", int'(code), ref_code);
         chk("R8 pulse per cycle", int'(upd), ref_upd);
         if (upd) pulses++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic open_frame(input int word, input int n);
      csn = 1'b0; ticks(4);
      for (int i = n - 1; i >= 0; i--) begin
         sdi = word[i]; sclk = 1'b0; ticks(4);
         sclk = 1'b1; ticks(4);
      end
      sclk = 1'b0; ticks(4);
   endtask

   task automatic close_frame();
      csn = 1'b1; ticks(8);
   endtask

   task automatic send(input int word, input int n);
      open_frame(word, n);
      close_frame();
   endtask

   task automatic strobe();
      ldn = 1'b0; ticks(4); ldn = 1'b1; ticks(6);
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      int p0;
      ticks(4);
      chk("R1 code in reset", int'(code), 0);
      chk("R1 pulse in reset", int'(upd), 0);
      rst_n = 1'b1;
      ticks(3);
      chk("R1 code after reset", int'(code), 0);

      // R2 + R9: 14-bit frame, copy on the third edge after select rises
      p0 = pulses;
      open_frame('h2A5C, 14);
      csn = 1'b1;
      ticks(2);
      chk("R9 not yet copied", int'(code), 0);
      ticks(1);
      chk("R9 copied on third edge", int'(code), 'h2A5C);
      ticks(6);
      chk("R2 14-bit frame", int'(code), 'h2A5C);
      chk("R8 one pulse per copy", pulses - p0, 1);

      // R3: 16-bit word keeps the low 14 bits
      send('hF123, 16);
      chk("R3 long frame", int'(code), 'h3123);

      // R4: 4-bit frame merges with previous contents
      send('hA, 4);
      chk("R4 short frame merge", int'(code), 'h123A);

      // R5: select pulse with no serial edge
      p0 = pulses;
      csn = 1'b0; ticks(8); close_frame();
      chk("R5 empty frame code", int'(code), 'h123A);
      chk("R5 empty frame pulse", pulses - p0, 0);

      // R10: serial edges while select is high, then a 2-bit frame
      for (int i = 0; i < 5; i++) begin
         sdi = 1'b1; sclk = 1'b1; ticks(4); sclk = 1'b0; ticks(4);
      end
      send('h3, 2);
      chk("R10 edges with select high ignored", int'(code), 'h08EB);

      // R6: strobed mode, select alone does nothing, strobe copies
      auto_upd = 1'b0; ticks(2);
      p0 = pulses;
      send('h1555, 14);
      chk("R6 no copy on select", int'(code), 'h08EB);
      chk("R6 no pulse on select", pulses - p0, 0);
      strobe();
      chk("R6 strobe copies", int'(code), 'h1555);
      chk("R8 one pulse for strobe", pulses - p0, 1);

      // R7: strobe inside an open frame is deferred
      open_frame('h0FF0, 14);
      strobe();
      chk("R7 held while select low", int'(code), 'h1555);
      close_frame();
      chk("R7 copied at select rise", int'(code), 'h0FF0);

      // R7/R6: a second closing select without strobe does not copy
      send('h0003, 14);
      chk("R6 pending cleared", int'(code), 'h0FF0);

      // back to automatic mode
      auto_upd = 1'b1; ticks(2);
      send('h3FFF, 14);
      chk("R2 all ones", int'(code), 'h3FFF);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule